// File: doc/BRIEF.md
# Paged SRAM Address Extension Unit

This block sits between an 8-bit processor core and a data SRAM organised as eight pages of 256 bytes. The core presents an 8-bit offset together with a code for the kind of access it is making (plain direct access, indexed access, stack access, or one of the three phases of an indirect move with post-increment). The block picks a page for that access from one of several independent page-pointer registers and outputs the full 11-bit SRAM address as page and offset concatenated.

The current-page pointer is only honoured when the two paging-mode flag bits from the core enable it. When they do not, direct accesses fall to page 0. Indexed and stack accesses each have their own pointer and ignore the current-page pointer. An indirect move fetches its pointer byte through the direct-page rule, but reads or writes the target byte in the page held by a dedicated read-move or write-move pointer.

Four 8-bit scratch registers live beside the page pointers. They have no hardware function and can be reached at any time through the register port, whatever page is selected. All registers are written and read through a simple register port. A write lands on the next clock edge. The address output is combinational from the current register contents and the access inputs.

Top module: `sram_page_extender`

## Requirements
- R1: After a synchronous active-low reset, every scratch register and every page pointer reads back 0, and every access class forms an address in page 0.
- R2: A direct access (class code 0) with mode_flags equal to 2'b10 or 2'b11 addresses {current page, offset}. The current page is the register at index 4.
- R3: A direct access with mode_flags equal to 2'b00 or 2'b01 addresses {3'b000, offset}, whatever the current page holds.
- R4: An indexed access (class code 1) addresses {index page, offset} for any mode_flags value. The index page is the register at index 6.
- R5: A stack access (class code 2) addresses {stack page, offset} for any mode_flags value. The stack page is the register at index 5.
- R6: An indirect-move pointer fetch (class code 3) follows the direct-access page rule of R2 and R3.
- R7: An indirect-move read target (class code 4) addresses {read-move page, offset}, and an indirect-move write target (class code 5) addresses {write-move page, offset}, for any mode_flags value. The read-move page is the register at index 7 and the write-move page is the register at index 8.
- R8: Register indices 0 to 3 are four 8-bit scratch registers that read back exactly the last byte written.
- R9: Page registers (indices 4 to 8) keep only write-data bits [2:0], and bits [7:3] read as 0. Indices 9 to 15 read as 0, and writes to them change no register.
- R10: A register write is visible on reg_rdata and sram_addr from the cycle after its write strobe. An access in the same cycle as the write uses the old value.
- R11: Unused class codes 6 and 7 address page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| acc_class | input | 3 | Access class code: 0 direct, 1 indexed, 2 stack, 3 move pointer fetch, 4 move read target, 5 move write target |
| mode_flags | input | 2 | Paging-mode flag bits from the core |
| acc_offset | input | 8 | Byte offset within the page |
| sram_addr | output | 11 | Full SRAM address {page, offset} |

## Verification
Two functions can fall in the same cycle: a register write to a page pointer and an access that selects that same pointer. The bench provokes this on purpose for each pointer. It writes a new page value while presenting the matching access class, then checks that sram_addr still carries the old page in that cycle and the new page in the cycle after. The rest of the run drives random writes and accesses together. A behavioural model, updated only after each comparison, judges every cycle.

// File: rtl/pgx_pkg.sv
// Package: shared constants and the access-class encoding for the paged
// SRAM address extension unit.
// Assumes page pointers are packed in this fixed order inside the register
// file, directly after the scratch registers.
package pgx_pkg;

    localparam int PTR_CNT = 5;

    // Pointer slots, in register-index order after the scratch registers
    localparam int PTR_CUR = 0;
    localparam int PTR_STK = 1;
    localparam int PTR_IDX = 2;
    localparam int PTR_MVR = 3;
    localparam int PTR_MVW = 4;

    // Access class codes reported by the core
    typedef enum logic [2:0] {
        ACC_DIRECT  = 3'd0,
        ACC_INDEXED = 3'd1,
        ACC_STACK   = 3'd2,
        ACC_MVI_PTR = 3'd3,
        ACC_MVI_RD  = 3'd4,
        ACC_MVI_WR  = 3'd5
    } acc_class_e;

endpackage

// File: rtl/pgx_regfile.sv
// Module: register file holding the scratch bytes and the page pointers.
// Indices 0..NSCR-1 are scratch registers. The next PTR_CNT indices are the
// page pointers, and any higher index reads 0 and ignores writes.
// Assumes PAGE_W <= DATA_W and NSCR + PTR_CNT <= 2**REG_AW.
module pgx_regfile
    import pgx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3,
    parameter int NSCR   = 4,
    parameter int REG_AW = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [REG_AW-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    output logic [DATA_W-1:0]                reg_rdata,
    output logic [PTR_CNT-1:0][PAGE_W-1:0]   ptr_q
);

    localparam int PTR_BASE = NSCR;

    logic [DATA_W-1:0] scr_r [NSCR];
    logic [PAGE_W-1:0] ptr_r [PTR_CNT];

    for (genvar s = 0; s < NSCR; s++) begin : g_scr
        // Scratch byte s: full-width storage, cleared on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                scr_r[s] <= '0;
            else if (reg_wr && reg_addr == REG_AW'(s))
                scr_r[s] <= reg_wdata;
        end
    end

    for (genvar p = 0; p < PTR_CNT; p++) begin : g_ptr
        // Page pointer p: keeps only the low PAGE_W bits of the write data
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_r[p] <= '0;
            else if (reg_wr && reg_addr == REG_AW'(PTR_BASE + p))
                ptr_r[p] <= reg_wdata[PAGE_W-1:0];
        end
        assign ptr_q[p] = ptr_r[p];
    end

    // Read mux: decoded index selects a register, reserved bits read 0
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NSCR; i++)
            if (reg_addr == REG_AW'(i))
                reg_rdata = scr_r[i];
        for (int i = 0; i < PTR_CNT; i++)
            if (reg_addr == REG_AW'(PTR_BASE + i))
                reg_rdata = DATA_W'(ptr_r[i]);
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ptr_q)) else $error("pointer changed without write"); // R10
    AST_CUR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(PTR_BASE + PTR_CUR))
        |=> ptr_q[PTR_CUR] == $past(reg_wdata[PAGE_W-1:0])) else $error("current page write lost"); // R9
    AST_RSVD_IDX_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= REG_AW'(PTR_BASE + PTR_CNT))
        |=> $stable(ptr_q)) else $error("reserved index changed a pointer"); // R9

endmodule

// File: rtl/pgx_page_sel.sv
// Module: chooses the page for one access from the access class, the
// paging-mode flags and the page pointers. It is purely combinational; clk
// and rst_n serve only the assertions next to the logic.
// Assumes flag bit 1 set means the current-page pointer is enabled.
module pgx_page_sel
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     acc_class,
    input  logic [1:0]                     mode_flags,
    input  logic [PTR_CNT-1:0][PAGE_W-1:0] ptr,
    output logic [PAGE_W-1:0]              page
);

    logic [PAGE_W-1:0] direct_page;
    acc_class_e        cls;

    assign cls = acc_class_e'(acc_class);

    // Direct-page rule: current page when enabled by the flags, else page 0
    always_comb begin
        direct_page = mode_flags[1] ? ptr[PTR_CUR] : '0;
    end

    // Class decode: each class picks its own pointer, unknown codes page 0
    always_comb begin
        case (cls)
            ACC_DIRECT,
            ACC_MVI_PTR: page = direct_page;
            ACC_INDEXED: page = ptr[PTR_IDX];
            ACC_STACK:   page = ptr[PTR_STK];
            ACC_MVI_RD:  page = ptr[PTR_MVR];
            ACC_MVI_WR:  page = ptr[PTR_MVW];
            default:     page = '0;
        endcase
    end

    AST_FLAGS_OFF_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == 3'd0 && !mode_flags[1]) |-> page == '0) else $error("direct page not 0"); // R3
    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_class == 3'd2 |-> page == ptr[PTR_STK]) else $error("stack page wrong"); // R5
    AST_INDEX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_class == 3'd1 |-> page == ptr[PTR_IDX]) else $error("index page wrong"); // R4
    AST_UNUSED_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        acc_class[2:1] == 2'b11 |-> page == '0) else $error("unused class not page 0"); // R11

endmodule

// File: rtl/sram_page_extender.sv
// Module: top of the paged SRAM address extension unit. It joins the
// register file and the page selector, and forms {page, offset}.
// Assumes the core holds acc_* stable while it samples sram_addr.
module sram_page_extender
    import pgx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 3,
    parameter int NSCR   = 4,
    parameter int REG_AW = 4,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [2:0]        acc_class,
    input  logic [1:0]        mode_flags,
    input  logic [OFS_W-1:0]  acc_offset,
    output logic [ADDR_W-1:0] sram_addr
);

    logic [PTR_CNT-1:0][PAGE_W-1:0] ptr_q;
    logic [PAGE_W-1:0]              sel_page;

    pgx_regfile #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W),
        .NSCR   (NSCR),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ptr_q     (ptr_q)
    );

    pgx_page_sel #(
        .PAGE_W (PAGE_W)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_class  (acc_class),
        .mode_flags (mode_flags),
        .ptr        (ptr_q),
        .page       (sel_page)
    );

    // Address former: page on top of the untouched offset
    always_comb begin
        sram_addr = {sel_page, acc_offset};
    end

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        sram_addr[OFS_W-1:0] == acc_offset) else $error("offset altered"); // R2
    AST_MVR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_class == 3'd4 |-> sram_addr[ADDR_W-1:OFS_W] == ptr_q[PTR_MVR]) else $error("read-move page wrong"); // R7
    AST_PTRFETCH_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == 3'd3 && mode_flags[1])
        |-> sram_addr[ADDR_W-1:OFS_W] == ptr_q[PTR_CUR]) else $error("pointer fetch page wrong"); // R6

endmodule

// File: tb/tb_sram_page_extender.sv
`timescale 1ns/1ps
module tb_sram_page_extender;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [2:0]  acc_class;
    logic [1:0]  mode_flags;
    logic [7:0]  acc_offset;
    logic [10:0] sram_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Behavioural model state: scratch bytes and pages cur, stk, idx, mvr, mvw
    int m_scr [4];
    int m_ptr [5];

    always #2.5 clk = ~clk;

    sram_page_extender dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_class(acc_class),
        .mode_flags(mode_flags), .acc_offset(acc_offset), .sram_addr(sram_addr)
    );

    function automatic int exp_page(int cls, int fl);
        case (cls)
            0, 3:    return (fl >= 2) ? m_ptr[0] : 0;
            1:       return m_ptr[2];
            2:       return m_ptr[1];
            4:       return m_ptr[3];
            5:       return m_ptr[4];
            default: return 0;
        endcase
    endfunction

    function automatic int exp_rd(int a);
        if (a < 4) return m_scr[a];
        if (a < 9) return m_ptr[a-4];
        return 0;
    endfunction

    function automatic string cls_req(int cls, int fl);
        case (cls)
            0:       return (fl >= 2) ? "R2" : "R3";
            1:       return "R4";
            2:       return "R5";
            3:       return "R6";
            4, 5:    return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic string rd_req(int a);
        if (a < 4) return "R8";
        return "R9";
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model
    task automatic step(bit rn, bit wr, int a, int wd, int cls, int fl, int ofs,
                        string tag_a = "", string tag_r = "");
        @(negedge clk);
        rst_n = rn; reg_wr = wr; reg_addr = 4'(a); reg_wdata = 8'(wd);
        acc_class = 3'(cls); mode_flags = 2'(fl); acc_offset = 8'(ofs);
        #1;
        if (rn) begin
            check(tag_a != "" ? tag_a : cls_req(cls, fl), int'(sram_addr),
                  exp_page(cls, fl) * 256 + ofs);
            check(tag_r != "" ? tag_r : rd_req(a), int'(reg_rdata), exp_rd(a));
        end
        if (!rn) begin
            foreach (m_scr[i]) m_scr[i] = 0;
            foreach (m_ptr[i]) m_ptr[i] = 0;
        end else if (wr) begin
            if (a < 4) m_scr[a] = wd & 8'hFF;
            else if (a < 9) m_ptr[a-4] = wd & 7;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        foreach (m_scr[i]) m_scr[i] = 0;
        foreach (m_ptr[i]) m_ptr[i] = 0;
        // Reset, with junk on the register port
        step(0, 1, 4, 8'hFF, 0, 3, 0);
        step(0, 1, 0, 8'hAA, 0, 3, 0);
        // R1: everything reads 0 and all classes land in page 0
        for (int a = 0; a < 9; a++) step(1, 0, a, 0, a % 6, 3, 8'h10 + a, "R1", "R1");
        // R8: scratch registers
        step(1, 1, 0, 8'hA5, 0, 0, 1);
        step(1, 1, 1, 8'h5A, 0, 0, 2);
        step(1, 1, 2, 8'hFF, 0, 0, 3);
        step(1, 1, 3, 8'h01, 0, 0, 4);
        for (int a = 0; a < 4; a++) step(1, 0, a, 0, 0, 0, 5);
        // R9: pointers keep 3 bits; junk in upper bits
        step(1, 1, 4, 8'hF5, 0, 2, 8'h20);
        step(1, 1, 5, 8'hE3, 0, 2, 8'h21);
        step(1, 1, 6, 8'h0E, 0, 2, 8'h22);
        step(1, 1, 7, 8'h79, 0, 2, 8'h23);
        step(1, 1, 8, 8'h8C, 0, 2, 8'h24);
        for (int a = 4; a < 9; a++) step(1, 0, a, 0, 0, 2, 8'h30);
        // R9: reserved indices read 0 and writes change nothing
        for (int a = 9; a < 16; a++) step(1, 1, a, 8'hFF, 0, 2, 8'h40);
        for (int a = 0; a < 16; a++) step(1, 0, a, 0, 0, 3, 8'h41);
        // R2..R7, R11: every class under every flag value
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 4; f++)
                step(1, 0, 15, 0, c, f, 8'h80 + c * 4 + f);
        // R10: same-cycle write and access to the same pointer
        for (int p = 0; p < 5; p++) begin
            int cls;
            cls = (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 1 : (p == 3) ? 4 : 5;
            step(1, 1, 4 + p, (m_ptr[p] + 3) & 7, cls, 3, 8'h55, "R10", "R10");
            step(1, 0, 4 + p, 0, cls, 3, 8'h56, "R10", "R10");
        end
        // Random traffic with concurrent writes and accesses
        for (int n = 0; n < 600; n++)
            step(1, ($urandom % 3) == 0, $urandom % 16, $urandom % 256,
                 $urandom % 8, $urandom % 4, $urandom % 256);
        // Reset again mid-run: R1
        step(0, 0, 0, 0, 0, 3, 0);
        for (int a = 4; a < 9; a++) step(1, 0, a, 0, a - 4, 3, 8'h77, "R1", "R1");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule